// File: doc/BRIEF.md
# Gated Codec Configuration Port

This block is a one-byte configuration port that sits in front of an audio codec on an ISA-style I/O bus. A host selects one of four base addresses, and the port answers at four consecutive byte addresses starting there. Every one of those addresses reaches the same register. The byte held in the port chooses the codec's DMA channel and interrupt line. Two fixed lookup tables turn bit fields of that byte into a DMA number and an IRQ number, and both are driven out as registered outputs.

Access is opened by either of two inputs from the surrounding control register bank: a port-enable bit, or the flag that shows codec mode is active. While both are low, reads return all ones and writes are dropped. An open read does not return the stored byte. It returns a status value: the constant 0x04 with bit 6 of the stored byte merged in.

Top module: `cfgport_top`

## Requirements
- R1: After reset the stored byte is 0x00, the DMA number is 0 and the IRQ number is 5.
- R2: Base select codes 0, 1, 2 and 3 place the port at 0x530, 0xE80, 0xF40 and 0x604.
- R3: The four addresses from base to base+3 all reach the same register, for both reads and writes.
- R4: When the port-enable input and the codec-mode input are both low, a write leaves the stored byte, DMA number and IRQ number unchanged.
- R5: When the port-enable input and the codec-mode input are both low, a read at a matching address returns 0xFF.
- R6: When either gate input is high, a read at a matching address returns 0x04 ORed with bit 6 of the stored byte, and all other bits are zero.
- R7: An open write at a matching address stores all eight data bits. The stored byte output shows the new value after the clock edge that accepts the write.
- R8: The DMA number comes from stored bits 1:0 through the table 0→0, 1→0, 2→1, 3→3. It updates on the same edge as the stored byte.
- R9: The IRQ number comes from stored bits 5:3 through the table 0→5, 1→7, 2→9, 3→10, 4→11, 5→12, 6→14, 7→15. It updates on the same edge as the stored byte.
- R10: An access at base−1 or base+4 does not match. Such a read returns 0xFF and such a write changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| bus_addr_i | input | ADDR_W | I/O address |
| bus_wr_i | input | 1 | Write strobe, one cycle per access |
| bus_rd_i | input | 1 | Read strobe |
| bus_wdata_i | input | 8 | Write data |
| base_sel_i | input | 2 | Base address select code |
| port_en_i | input | 1 | Port-enable bit from the control register bank |
| codec_mode_i | input | 1 | Codec mode active flag |
| bus_rdata_o | output | 8 | Read data; 0xFF when the port does not answer |
| cfg_byte_o | output | 8 | Stored configuration byte |
| dma_num_o | output | 2 | Decoded DMA channel number |
| irq_num_o | output | 4 | Decoded IRQ line number |

## Verification
For every base select code, the bench writes and then reads each address from one below the window to one past it. This separates the four aliased hits from the two neighbours that must miss. All 256 byte values are then written through one alias. This checks full-byte storage, every DMA and IRQ table entry, and the readback mask on both values of bit 6. Finally, all four combinations of port enable and codec mode are tried. This shows that either input alone opens the port and that with both low the port stays closed for both reads and writes.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

    localparam int DATA_W    = 8;
    localparam int DMA_NUM_W = 2;
    localparam int IRQ_NUM_W = 4;
    localparam int BASE_W    = 12;

    localparam logic [DATA_W-1:0] STATUS_CONST = 8'h04;
    localparam logic [DATA_W-1:0] STATUS_MASK  = 8'h40;
    localparam logic [DATA_W-1:0] IDLE_READ    = 8'hFF;
    localparam logic [DATA_W-1:0] RESET_CFG    = 8'h00;

    typedef struct packed {
        logic [DATA_W-1:0]    cfg;
        logic [DMA_NUM_W-1:0] dma;
        logic [IRQ_NUM_W-1:0] irq;
    } cfg_state_t;

    function automatic logic [BASE_W-1:0] base_lookup(input logic [1:0] sel);
        logic [BASE_W-1:0] b;
        case (sel)
            2'd0:    b = 12'h530;
            2'd1:    b = 12'hE80;
            2'd2:    b = 12'hF40;
            default: b = 12'h604;
        endcase
        return b;
    endfunction

    function automatic logic [DMA_NUM_W-1:0] dma_lookup(input logic [1:0] idx);
        logic [DMA_NUM_W-1:0] d;
        case (idx)
            2'd0:    d = 2'd0;
            2'd1:    d = 2'd0;
            2'd2:    d = 2'd1;
            default: d = 2'd3;
        endcase
        return d;
    endfunction

    function automatic logic [IRQ_NUM_W-1:0] irq_lookup(input logic [2:0] idx);
        logic [IRQ_NUM_W-1:0] q;
        case (idx)
            3'd0:    q = 4'd5;
            3'd1:    q = 4'd7;
            3'd2:    q = 4'd9;
            3'd3:    q = 4'd10;
            3'd4:    q = 4'd11;
            3'd5:    q = 4'd12;
            3'd6:    q = 4'd14;
            default: q = 4'd15;
        endcase
        return q;
    endfunction

endpackage

// File: rtl/cfgport_addr_match.sv
module cfgport_addr_match
    import cfgport_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int SPAN   = 4
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        base_sel_i,
    output logic              hit_o
);

    logic [ADDR_W-1:0] base_w;
    logic [SPAN-1:0]   hit_vec;

    assign base_w = ADDR_W'(base_lookup(base_sel_i));

    for (genvar i = 0; i < SPAN; i++) begin : g_alias
        assign hit_vec[i] = (addr_i == (base_w + ADDR_W'(i)));
    end

    assign hit_o = |hit_vec;

endmodule

// File: rtl/cfgport_gate.sv
module cfgport_gate (
    input  logic hit_i,
    input  logic wr_i,
    input  logic rd_i,
    input  logic port_en_i,
    input  logic codec_mode_i,
    output logic wr_acc_o,
    output logic rd_acc_o
);

    logic open_w;

    assign open_w   = port_en_i | codec_mode_i;
    assign wr_acc_o = wr_i & hit_i & open_w;
    assign rd_acc_o = rd_i & hit_i & open_w;

endmodule

// File: rtl/cfgport_store.sv
module cfgport_store
    import cfgport_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_acc_i,
    input  logic [DATA_W-1:0] wdata_i,
    output cfg_state_t        state_o
);

    cfg_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (wr_acc_i) begin
            state_d.cfg = wdata_i;
            state_d.dma = dma_lookup(wdata_i[1:0]);
            state_d.irq = irq_lookup(wdata_i[5:3]);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q.cfg <= RESET_CFG;
            state_q.dma <= dma_lookup(RESET_CFG[1:0]);
            state_q.irq <= irq_lookup(RESET_CFG[5:3]);
        end else begin
            state_q <= state_d;
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/cfgport_top.sv
module cfgport_top
    import cfgport_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int SPAN   = 4
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [ADDR_W-1:0]    bus_addr_i,
    input  logic                 bus_wr_i,
    input  logic                 bus_rd_i,
    input  logic [7:0]           bus_wdata_i,
    input  logic [1:0]           base_sel_i,
    input  logic                 port_en_i,
    input  logic                 codec_mode_i,
    output logic [7:0]           bus_rdata_o,
    output logic [7:0]           cfg_byte_o,
    output logic [DMA_NUM_W-1:0] dma_num_o,
    output logic [IRQ_NUM_W-1:0] irq_num_o
);

    logic       hit_w;
    logic       wr_acc_w;
    logic       rd_acc_w;
    cfg_state_t state_w;

    cfgport_addr_match #(.ADDR_W(ADDR_W), .SPAN(SPAN)) match_i (
        .addr_i     (bus_addr_i),
        .base_sel_i (base_sel_i),
        .hit_o      (hit_w)
    );

    cfgport_gate gate_i (
        .hit_i        (hit_w),
        .wr_i         (bus_wr_i),
        .rd_i         (bus_rd_i),
        .port_en_i    (port_en_i),
        .codec_mode_i (codec_mode_i),
        .wr_acc_o     (wr_acc_w),
        .rd_acc_o     (rd_acc_w)
    );

    cfgport_store store_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_acc_i (wr_acc_w),
        .wdata_i  (bus_wdata_i),
        .state_o  (state_w)
    );

    always_comb begin
        if (rd_acc_w) begin
            bus_rdata_o = STATUS_CONST | (state_w.cfg & STATUS_MASK);
        end else begin
            bus_rdata_o = IDLE_READ;
        end
    end

    assign cfg_byte_o = state_w.cfg;
    assign dma_num_o  = state_w.dma;
    assign irq_num_o  = state_w.irq;

endmodule

// File: rtl/cfgport_checker.sv
module cfgport_checker #(
    parameter int ADDR_W = 16
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              bus_wr_i,
    input logic              bus_rd_i,
    input logic [7:0]        bus_wdata_i,
    input logic              port_en_i,
    input logic              codec_mode_i,
    input logic              hit_w,
    input logic [7:0]        bus_rdata_o,
    input logic [7:0]        cfg_byte_o,
    input logic [1:0]        dma_num_o,
    input logic [3:0]        irq_num_o
);

    logic open_c;
    assign open_c = port_en_i | codec_mode_i;

    assert_store_full_byte_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_wr_i && hit_w && open_c) |=> (cfg_byte_o == $past(bus_wdata_i)));

    assert_closed_write_keeps_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_wr_i && !open_c) |=> $stable(cfg_byte_o));

    assert_closed_read_ff_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_rd_i && hit_w && !open_c) |-> (bus_rdata_o == 8'hFF));

    assert_open_read_status_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_rd_i && hit_w && open_c) |->
            (((bus_rdata_o & 8'hBF) == 8'h04) && (bus_rdata_o[6] == cfg_byte_o[6])));

    assert_dma_legal_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dma_num_o != 2'd2));

    assert_irq_follows_cfg_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $stable(cfg_byte_o) |-> $stable(irq_num_o));

    assert_miss_read_ff_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_rd_i && !hit_w) |-> (bus_rdata_o == 8'hFF));

endmodule

bind cfgport_top cfgport_checker #(.ADDR_W(ADDR_W)) chk_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .bus_wr_i     (bus_wr_i),
    .bus_rd_i     (bus_rd_i),
    .bus_wdata_i  (bus_wdata_i),
    .port_en_i    (port_en_i),
    .codec_mode_i (codec_mode_i),
    .hit_w        (hit_w),
    .bus_rdata_o  (bus_rdata_o),
    .cfg_byte_o   (cfg_byte_o),
    .dma_num_o    (dma_num_o),
    .irq_num_o    (irq_num_o)
);

// File: tb/cfgport_top_tb_top.sv
module cfgport_top_tb_top;

    localparam int ADDR_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic              wr = 1'b0;
    logic              rd = 1'b0;
    logic [7:0]        wdata = '0;
    logic [1:0]        base_sel = '0;
    logic              port_en = 1'b0;
    logic              mode = 1'b0;
    logic [7:0]        rdata;
    logic [7:0]        cfg;
    logic [1:0]        dma;
    logic [3:0]        irq;

    int n_tests = 0;
    int n_fail  = 0;
    logic [7:0] exp_cfg = 8'h00;

    always #4 clk = ~clk;

    cfgport_top #(.ADDR_W(ADDR_W)) dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .bus_addr_i   (addr),
        .bus_wr_i     (wr),
        .bus_rd_i     (rd),
        .bus_wdata_i  (wdata),
        .base_sel_i   (base_sel),
        .port_en_i    (port_en),
        .codec_mode_i (mode),
        .bus_rdata_o  (rdata),
        .cfg_byte_o   (cfg),
        .dma_num_o    (dma),
        .irq_num_o    (irq)
    );

    function automatic int exp_base(input int s);
        case (s)
            0: return 'h530;
            1: return 'hE80;
            2: return 'hF40;
            default: return 'h604;
        endcase
    endfunction

    function automatic int exp_dma(input logic [7:0] v);
        int i = int'(v[1:0]);
        return (i == 3) ? 3 : ((i == 2) ? 1 : 0);
    endfunction

    function automatic int exp_irq(input logic [7:0] v);
        int i = int'(v[5:3]);
        if (i < 2) return 5 + 2 * i;
        if (i < 6) return 9 + (i - 2);
        return 14 + (i - 6);
    endfunction

    function automatic logic [7:0] exp_status(input logic [7:0] v);
        return 8'h04 | (v & 8'h40);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
        end
    endtask

    task automatic do_write(input int a, input logic [7:0] v);
        @(negedge clk);
        addr  = ADDR_W'(a);
        wdata = v;
        wr    = 1'b1;
        @(negedge clk);
        wr    = 1'b0;
    endtask

    task automatic do_read(input int a, output logic [7:0] v);
        @(negedge clk);
        addr = ADDR_W'(a);
        rd   = 1'b1;
        #1;
        v = rdata;
        @(negedge clk);
        rd   = 1'b0;
    endtask

    task automatic check_state(input string req);
        check(cfg == exp_cfg, req, int'(cfg), int'(exp_cfg));
        check(int'(dma) == exp_dma(exp_cfg), req, int'(dma), exp_dma(exp_cfg));
        check(int'(irq) == exp_irq(exp_cfg), req, int'(irq), exp_irq(exp_cfg));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        logic [7:0] rv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset values
        check_state("R1");

        // R5: closed read at a hit address
        do_read('h530, rv);
        check(rv == 8'hFF, "R5", int'(rv), 'hFF);

        // R2 R3 R10: window sweep for each base code
        port_en = 1'b1;
        for (int s = 0; s < 4; s++) begin
            base_sel = 2'(s);
            for (int off = -1; off <= 4; off++) begin
                logic [7:0] v;
                bit hit;
                hit = (off >= 0) && (off < 4);
                v = 8'(s * 37 + (off + 1) * 11 + ((off & 1) != 0 ? 64 : 0));
                do_write(exp_base(s) + off, v);
                if (hit) exp_cfg = v;
                check_state(hit ? "R3" : "R10");
                do_read(exp_base(s) + off, rv);
                if (hit)
                    check(rv == exp_status(exp_cfg), "R2", int'(rv), int'(exp_status(exp_cfg)));
                else
                    check(rv == 8'hFF, "R10", int'(rv), 'hFF);
            end
        end

        // R7 R8 R9 R6: all byte values through one alias
        base_sel = 2'd3;
        for (int v = 0; v < 256; v++) begin
            do_write(exp_base(3) + 2, 8'(v));
            exp_cfg = 8'(v);
            check(cfg == exp_cfg, "R7", int'(cfg), int'(exp_cfg));
            check(int'(dma) == exp_dma(exp_cfg), "R8", int'(dma), exp_dma(exp_cfg));
            check(int'(irq) == exp_irq(exp_cfg), "R9", int'(irq), exp_irq(exp_cfg));
            if ((v % 16) == 0 || v == 8'h40 || v == 8'hBF) begin
                do_read(exp_base(3) + 1, rv);
                check(rv == exp_status(exp_cfg), "R6", int'(rv), int'(exp_status(exp_cfg)));
            end
        end

        // R4 R5 R6: gate combinations
        base_sel = 2'd1;
        for (int g = 0; g < 4; g++) begin
            logic [7:0] v;
            bit open;
            port_en = g[0];
            mode    = g[1];
            open    = (g != 0);
            v = 8'hA5 ^ 8'(g * 8'h11);
            do_write(exp_base(1), v);
            if (open) exp_cfg = v;
            check_state(open ? "R7" : "R4");
            do_read(exp_base(1) + 3, rv);
            if (open)
                check(rv == exp_status(exp_cfg), "R6", int'(rv), int'(exp_status(exp_cfg)));
            else
                check(rv == 8'hFF, "R5", int'(rv), 'hFF);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule